// File: doc/BRIEF.md
# Port Key-Event Detector

This block watches a small input port, by default eight lines, for key presses. Each line can be turned on as a key input on its own. Each line also has its own choice of active level, low or high. An active level on an enabled line is first synchronised. It then sets a sticky flag bit for that line. The flag stays set until software clears it through a byte-wide register interface. Any set flag raises a single interrupt request when the interrupt-enable input is high.

A separate wake output is formed without any clock from the raw pin levels, the enable bits and the level bits. It can therefore bring the system out of a clock-stopped sleep state. The block only raises requests. Interrupt arbitration, vectoring and power-state sequencing are handled elsewhere.

The register interface uses plain strobes and has no flow control. A write takes effect at the rising edge where `reg_wr_i` is high. Read data is combinational while `reg_rd_i` is high.

Top module: `kbd_event_ctrl`

## Requirements
- R1: After reset, the enable register, the flag register and the level register all read 0x00, and `irq_o` is low.
- R2: Select code 0 addresses the enable register. A write stores the data byte, and a read returns it. While `reg_rd_i` is low, `reg_rdata_o` is 0x00. Select code 3 reads 0x00, and writes to it change no register.
- R3: Select code 2 addresses the level register, which is written and read back in the same way. For each line, bit value 0 makes a low pin level the active level, and bit value 1 makes a high pin level the active level.
- R4: An active level on an enabled line sets that line's flag bit (bit i for line i, read at select code 1) at the third rising edge after the pin changes. The flag is not yet set after the second rising edge.
- R5: A line whose enable bit is 0 never sets its flag bit, whatever its pin level.
- R6: A flag bit stays set after its pin returns to the inactive level, until software clears it.
- R7: A write to select code 1 clears every flag bit whose data bit is 0 and keeps every flag bit whose data bit is 1. Writing 0x00 clears all flag bits.
- R8: If a line is detecting an active event in the same cycle as a clearing write to its flag bit, the flag bit stays set.
- R9: `irq_o` is high exactly when `irq_en_i` is high and at least one flag bit is set. It stays high until every flag bit has been cleared.
- R10: `wake_o` is high, with no clock edge needed, whenever some enabled line's raw pin sits at that line's active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | N_LINES | Raw port lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_sel_i | input | 2 | Register select: 0 enable, 1 flag, 2 level, 3 none |
| reg_wdata_i | input | N_LINES | Write data |
| reg_rdata_o | output | N_LINES | Read data (0 when not reading) |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Unclocked wake request |

## Verification
Each result has a fixed due time, and the bench samples at exactly that time.

- The wake output depends only on the current pin, enable and level values. It is checked one nanosecond after the pin is driven, before any clock edge.
- A flag is due at the third rising edge after a pin change. The bench checks that it is still clear after two edges and set after three.
- Register writes and flag clears land at the edge that samples the strobe, and the interrupt follows the flags with no extra delay. Both are read at the next falling edge.

The main check sweeps every line, under both level settings, with the line either enabled alone or with every other line enabled. The expected flag byte is computed from the line index in each case.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_FLAG   = 2'd1,
    SEL_LEVEL  = 2'd2,
    SEL_NONE   = 2'd3
  } kbd_sel_e;
endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q[g] <= 1'b0;
        stage2_q[g] <= 1'b0;
      end else begin
        stage1_q[g] <= d_i[g];
        stage2_q[g] <= stage1_q[g];
      end
    end
  end

  assign q_o = stage2_q;

  // cycles since reset, used only to keep the latency check within history
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  p_sync_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/kbd_flag_cell.sv
module kbd_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic act_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic evt;

  assign evt = en_i & act_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (evt)   flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_disabled_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !flag_q) |=> !flag_q);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && act_i && clr_i) |=> flag_q);
endmodule

// File: rtl/kbd_reg_file.sv
module kbd_reg_file
  import kbd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             rd_i,
  input  kbd_sel_e         sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] flags_i,
  output logic [WIDTH-1:0] en_o,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] en_q;
  logic [WIDTH-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      lvl_q <= '0;
    end else if (wr_i) begin
      if (sel_i == SEL_ENABLE) en_q  <= wdata_i;
      if (sel_i == SEL_LEVEL)  lvl_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (sel_i)
        SEL_ENABLE: rdata_o = en_q;
        SEL_FLAG:   rdata_o = flags_i;
        SEL_LEVEL:  rdata_o = lvl_q;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign en_o  = en_q;
  assign lvl_o = lvl_q;

  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && sel_i == SEL_ENABLE) |=> $stable(en_q));
  p_lvl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && sel_i == SEL_LEVEL) |=> $stable(lvl_q));
  p_idle_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |-> (rdata_o == '0));
endmodule

// File: rtl/kbd_event_ctrl.sv
module kbd_event_ctrl
  import kbd_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pin_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [1:0]         reg_sel_i,
  input  logic [N_LINES-1:0] reg_wdata_i,
  output logic [N_LINES-1:0] reg_rdata_o,
  input  logic               irq_en_i,
  output logic               irq_o,
  output logic               wake_o
);
  kbd_sel_e           sel;
  logic [N_LINES-1:0] pin_sync;
  logic [N_LINES-1:0] en;
  logic [N_LINES-1:0] lvl;
  logic [N_LINES-1:0] flags;
  logic [N_LINES-1:0] act_sync;
  logic [N_LINES-1:0] clr;
  logic               flag_wr;

  assign sel     = kbd_sel_e'(reg_sel_i);
  assign flag_wr = reg_wr_i && (sel == SEL_FLAG);

  kbd_line_sync #(.WIDTH(N_LINES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pin_i),
    .q_o  (pin_sync)
  );

  kbd_reg_file #(.WIDTH(N_LINES)) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (reg_wr_i),
    .rd_i   (reg_rd_i),
    .sel_i  (sel),
    .wdata_i(reg_wdata_i),
    .flags_i(flags),
    .en_o   (en),
    .lvl_o  (lvl),
    .rdata_o(reg_rdata_o)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    assign act_sync[g] = ~(pin_sync[g] ^ lvl[g]);
    assign clr[g]      = flag_wr & ~reg_wdata_i[g];
    kbd_flag_cell cell_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (en[g]),
      .act_i (act_sync[g]),
      .clr_i (clr[g]),
      .flag_o(flags[g])
    );
  end

  assign irq_o  = irq_en_i & (|flags);
  assign wake_o = |(en & ~(pin_i ^ lvl));

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !irq_o);
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !flag_wr) |=> (irq_o || !irq_en_i));
  p_wake_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !wake_o);
endmodule

// File: tb/kbd_event_ctrl_tb_top.sv
module kbd_event_ctrl_tb_top;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pin_i = '1;
  logic reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [1:0] reg_sel_i = 2'd0;
  logic [N-1:0] reg_wdata_i = '0;
  logic [N-1:0] reg_rdata_o;
  logic irq_en_i = 1'b0;
  logic irq_o, wake_o;
  int n_chk = 0, n_bad = 0;
  logic [N-1:0] rd;

  always #4 clk = ~clk;

  kbd_event_ctrl #(.N_LINES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .irq_en_i(irq_en_i), .irq_o(irq_o), .wake_o(wake_o));

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [N-1:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_sel_i = s; reg_wdata_i = d;
    @(posedge clk); #1;
    reg_wr_i = 1'b0;
  endtask

  task automatic rdr(input logic [1:0] s, output logic [N-1:0] v);
    @(negedge clk);
    reg_rd_i = 1'b1; reg_sel_i = s;
    #1 v = reg_rdata_o;
    reg_rd_i = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    cyc(3); #1 rst_n = 1'b1;
    // R1 reset state
    rdr(2'd0, rd); check("R1 enable", rd, 8'h00);
    rdr(2'd1, rd); check("R1 flag", rd, 8'h00);
    rdr(2'd2, rd); check("R1 level", rd, 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    // R2 register access
    wr(2'd0, 8'hA5); rdr(2'd0, rd); check("R2 enable readback", rd, 8'hA5);
    @(negedge clk); #1 check("R2 idle read", reg_rdata_o, 8'h00);
    wr(2'd3, 8'hFF); rdr(2'd3, rd); check("R2 select 3 read", rd, 8'h00);
    rdr(2'd0, rd); check("R2 select 3 write ignored", rd, 8'hA5);
    wr(2'd0, 8'h00);
    // R3 level register
    wr(2'd2, 8'h3C); rdr(2'd2, rd); check("R3 level readback", rd, 8'h3C);

    irq_en_i = 1'b1;
    // Sweep: R3 R4 R5 R6 R7 R9 R10
    for (int l = 0; l < 2; l++) begin
      logic [N-1:0] lmask;
      lmask = (l == 1) ? 8'hFF : 8'h00;
      wr(2'd0, 8'h00);
      wr(2'd2, lmask);
      @(negedge clk); pin_i = ~lmask;
      cyc(4);
      wr(2'd1, 8'h00);
      for (int i = 0; i < N; i++) begin
        for (int m = 0; m < 2; m++) begin
          logic [N-1:0] bitv, expf;
          bitv = 8'h01 << i;
          expf = (m == 1) ? bitv : 8'h00;
          wr(2'd0, (m == 1) ? bitv : ~bitv);
          @(negedge clk); pin_i = ~lmask ^ bitv;
          #1 check("R10 wake immediate", {7'd0, wake_o}, {7'd0, m[0]});
          cyc(2);
          rdr(2'd1, rd); check("R4 not yet after two edges", rd, 8'h00);
          cyc(1);
          rdr(2'd1, rd); check("R4 R5 R3 flag after three edges", rd, expf);
          #1 check("R9 irq", {7'd0, irq_o}, {7'd0, m[0]});
          pin_i = ~lmask;
          cyc(4);
          rdr(2'd1, rd); check("R6 flag sticky", rd, expf);
          wr(2'd1, 8'h00);
          rdr(2'd1, rd); check("R7 clear all", rd, 8'h00);
          #1 check("R9 irq drops", {7'd0, irq_o}, 8'h00);
        end
      end
    end

    // R7 partial clear and R9 hold, low-active lines 0 and 3
    wr(2'd0, 8'h00); wr(2'd2, 8'h00);
    @(negedge clk); pin_i = 8'hFF; cyc(4); wr(2'd1, 8'h00);
    wr(2'd0, 8'h09);
    @(negedge clk); pin_i = 8'hF6; cyc(4);
    @(negedge clk); pin_i = 8'hFF; cyc(4);
    rdr(2'd1, rd); check("R6 two flags", rd, 8'h09);
    irq_en_i = 1'b0;
    @(negedge clk); #1 check("R9 gated off", {7'd0, irq_o}, 8'h00);
    irq_en_i = 1'b1;
    wr(2'd1, 8'hF7);
    rdr(2'd1, rd); check("R7 partial clear", rd, 8'h01);
    #1 check("R9 irq holds while a flag remains", {7'd0, irq_o}, 8'h01);
    wr(2'd1, 8'h00);
    #1 check("R9 irq low once all cleared", {7'd0, irq_o}, 8'h00);

    // R8 event wins against clear
    wr(2'd0, 8'h04);
    @(negedge clk); pin_i = 8'hFB; cyc(4);
    wr(2'd1, 8'h00);
    rdr(2'd1, rd); check("R8 event beats clear", rd, 8'h04);
    @(negedge clk); pin_i = 8'hFF; cyc(4);
    wr(2'd1, 8'h00);
    rdr(2'd1, rd); check("R8 clear after event ends", rd, 8'h00);

    // R5 disabled line at active level, no wake either
    wr(2'd0, 8'h00);
    @(negedge clk); pin_i = 8'h00;
    #1 check("R10 no wake when disabled", {7'd0, wake_o}, 8'h00);
    cyc(5);
    rdr(2'd1, rd); check("R5 disabled lines no flag", rd, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule